// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns a set of external input lines into latched, maskable interrupt requests. Sixteen lines each take their source from one pin position on one of several GPIO ports. A per-line code chooses the port. Four more lines come straight from auxiliary inputs. Each line's source passes through a two-flop synchronizer. The synchronized value is then compared with its value one clock earlier to find rising and falling edges.

Software picks the edges per line with two enable registers, one for rising edges and one for falling edges. A qualifying edge sets the line's pending flag, and software clears that flag by writing a one to it. The pending flags of the sixteen port-sourced lines are ANDed with a mask. The results drive seven interrupt outputs: five lines have an output each, and two groups of lines share one output each.

Configuration goes through a plain write strobe with a word address. The read data is a combinational function of the address.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: When a line's rising-enable bit is set, a 0-to-1 change on its selected source sets its pending bit. The bit is readable at address 3 after the third rising clock edge that follows the input change.
- R3: When a line's falling-enable bit is set, a 1-to-0 change on its selected source sets its pending bit, with the same latency as R2.
- R4: When both enable bits of a line are set, each edge in either direction sets the pending bit.
- R5: A line whose rising and falling enable bits are both clear never sets its pending bit, whatever its input does.
- R6: A write to address 3 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R7: If a pending bit is cleared and a new edge sets it in the same cycle, the set wins and the bit stays 1.
- R8: An interrupt output is asserted only if some contributing line has both its pending and mask bits at 1. An edge on a masked line still sets its pending bit.
- R9: Output `irq_o[k]` serves line k for k = 0 to 4. `irq_o[5]` is the OR over lines 5 to 9, and `irq_o[6]` is the OR over lines 10 to 15. A grouped output stays high until every contributing pending bit is cleared.
- R10: Line n (0 to 15) has a 4-bit select field. The field sits at bits 4*(n mod 4) of the select word at address 4 + n/4. Code k in the range 0 to 3 picks `port_i[16*k + n]`. Codes 4 to 15 pick constant 0.
- R11: Lines 16 to 19 take their source from `aux_i[0..3]` and hold pending bits 16 to 19. They never drive any interrupt output.
- R12: The register map is as follows: address 0 is the mask, 1 is the rising enables, 2 is the falling enables and 3 is the pending flags, each in bits 19:0. Addresses 4 to 7 are the select words in bits 15:0. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| port_i | input | 64 | Four 16-pin GPIO ports, port k at bits 16k+15:16k |
| aux_i | input | 4 | Direct sources for lines 16 to 19 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 7 | Grouped interrupt requests |

## Verification
The assertions check the following on every cycle:
- an edge report always matches the input value two clocks earlier;
- a pending bit appears only where an enabled edge occurred, and a write-one-to-clear removes it unless a new set arrives in the same cycle;
- an interrupt output needs a pending and unmasked port line;
- a reserved select code yields a quiet source.

Only the bench's scenarios show the edge-to-flag latency, the exact grouping of lines onto outputs, a shared output holding through a partial clear, and the register layout read back through the bus.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int NUM_PORTS    = 4;
    localparam int PORT_PINS    = 16;
    localparam int SRC_LINES    = 16;
    localparam int AUX_LINES    = 4;
    localparam int NUM_LINES    = SRC_LINES + AUX_LINES;
    localparam int SEL_W        = 4;
    localparam int SEL_PER_WORD = 4;
    localparam int SEL_WORD_W   = SEL_W * SEL_PER_WORD;
    localparam int SEL_WORDS    = SRC_LINES / SEL_PER_WORD;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int DIRECT_IRQ   = 5;
    localparam int GROUP_A_END  = 10;
    localparam int NUM_IRQ      = DIRECT_IRQ + 2;
    localparam int PORT_BUS_W   = NUM_PORTS * PORT_PINS;

    localparam logic [ADDR_W-1:0] REG_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] REG_RISE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_FALL = 3'd2;
    localparam logic [ADDR_W-1:0] REG_PEND = 3'd3;
    localparam logic [ADDR_W-1:0] REG_SEL0 = 3'd4;

    typedef struct packed {
        logic [NUM_LINES-1:0]         mask;
        logic [NUM_LINES-1:0]         rise;
        logic [NUM_LINES-1:0]         fall;
        logic [NUM_LINES-1:0]         pend;
        logic [SRC_LINES*SEL_W-1:0]   sel;
    } cfg_t;

    // Fixed many-to-few mapping of port-sourced lines onto outputs.
    function automatic int irq_of_line(input int line);
        if (line < DIRECT_IRQ)       return line;
        else if (line < GROUP_A_END) return DIRECT_IRQ;
        else                         return DIRECT_IRQ + 1;
    endfunction

endpackage

// File: rtl/eirq_src_mux.sv
module eirq_src_mux
    import eirq_pkg::*;
(
    input  logic [PORT_BUS_W-1:0]        port_i,
    input  logic [SRC_LINES*SEL_W-1:0]   sel_i,
    output logic [SRC_LINES-1:0]         line_o
);

    for (genvar l = 0; l < SRC_LINES; l++) begin : g_line
        logic [SEL_W-1:0] code;
        logic             pick;
        assign code = sel_i[l*SEL_W +: SEL_W];
        always_comb begin
            pick = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (int'(code) == p) pick = port_i[p*PORT_PINS + l];
            end
        end
        assign line_o[l] = pick;
    end

endmodule

// File: rtl/eirq_edge_det.sv
module eirq_edge_det #(
    parameter int W = 20
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
    assign fall_o = ~st_q.s2 & st_q.prev;

    // A reported rising edge must match a high input two clocks back.
    assert_rise_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise_o & ~$past(din_i, 2)) == '0));

    // A reported falling edge must match a low input two clocks back.
    assert_fall_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((fall_o & $past(din_i, 2)) == '0));

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_LINES-1:0] rise_ev_i,
    input  logic [NUM_LINES-1:0] fall_ev_i,
    output cfg_t                 cfg_o
);

    cfg_t                 cfg_d, cfg_q;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] clr_vec;
    int                   sel_idx;

    always_comb begin
        cfg_d   = cfg_q;
        set_vec = (rise_ev_i & cfg_q.rise) | (fall_ev_i & cfg_q.fall);
        clr_vec = '0;
        sel_idx = int'(addr_i) - int'(REG_SEL0);
        if (wr_en_i) begin
            case (addr_i)
                REG_MASK: cfg_d.mask = wdata_i[NUM_LINES-1:0];
                REG_RISE: cfg_d.rise = wdata_i[NUM_LINES-1:0];
                REG_FALL: cfg_d.fall = wdata_i[NUM_LINES-1:0];
                REG_PEND: clr_vec    = wdata_i[NUM_LINES-1:0];
                default:  cfg_d.sel[sel_idx*SEL_WORD_W +: SEL_WORD_W] =
                              wdata_i[SEL_WORD_W-1:0];
            endcase
        end
        // A fresh event outranks a clear of the same bit.
        cfg_d.pend = (cfg_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == REG_PEND) |=>
        ((cfg_q.pend & $past(wdata_i[NUM_LINES-1:0] & ~set_vec)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_vec) |=> ((cfg_q.pend & $past(set_vec)) == $past(set_vec)));

    assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cfg_q.pend & ~$past(cfg_q.pend) &
          ~$past((rise_ev_i & cfg_q.rise) | (fall_ev_i & cfg_q.fall))) == '0));

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PORT_BUS_W-1:0] port_i,
    input  logic [AUX_LINES-1:0]  aux_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [NUM_IRQ-1:0]    irq_o
);

    cfg_t                 cfg;
    logic [SRC_LINES-1:0] src_line;
    logic [NUM_LINES-1:0] rise_ev;
    logic [NUM_LINES-1:0] fall_ev;
    logic [NUM_IRQ-1:0]   irq_v;
    int                   rd_idx;

    eirq_src_mux u_mux (
        .port_i (port_i),
        .sel_i  (cfg.sel),
        .line_o (src_line)
    );

    eirq_edge_det #(.W(NUM_LINES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({aux_i, src_line}),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    eirq_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rise_ev_i (rise_ev),
        .fall_ev_i (fall_ev),
        .cfg_o     (cfg)
    );

    always_comb begin
        irq_v = '0;
        for (int l = 0; l < SRC_LINES; l++) begin
            irq_v[irq_of_line(l)] = irq_v[irq_of_line(l)] | (cfg.pend[l] & cfg.mask[l]);
        end
    end
    assign irq_o = irq_v;

    always_comb begin
        rdata_o = '0;
        rd_idx  = int'(addr_i) - int'(REG_SEL0);
        case (addr_i)
            REG_MASK: rdata_o = DATA_W'(cfg.mask);
            REG_RISE: rdata_o = DATA_W'(cfg.rise);
            REG_FALL: rdata_o = DATA_W'(cfg.fall);
            REG_PEND: rdata_o = DATA_W'(cfg.pend);
            default:  rdata_o = DATA_W'(cfg.sel[rd_idx*SEL_WORD_W +: SEL_WORD_W]);
        endcase
    end

    assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o != '0) |-> ((cfg.pend & cfg.mask) != '0));

    assert_aux_no_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cfg.pend[SRC_LINES-1:0] & cfg.mask[SRC_LINES-1:0]) == '0) |-> (irq_o == '0));

    for (genvar l = 0; l < SRC_LINES; l++) begin : g_sel_chk
        assert_unused_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (int'(cfg.sel[l*SEL_W +: SEL_W]) >= NUM_PORTS) |-> !src_line[l]);
    end

endmodule

// File: tb/eirq_ctrl_tb.sv
`timescale 1ns/1ps
module eirq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] port_i = '0;
    logic [3:0]  aux_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd3;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eirq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .port_i(port_i), .aux_i(aux_i),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [19:0] m_mask, m_rise, m_fall, m_pend, m_a, m_b, m_c;
    int          m_sel [16];

    always @(posedge clk) begin
        logic [19:0] src, setv, clrv;
        if (!rst_n) begin
            m_mask = '0; m_rise = '0; m_fall = '0; m_pend = '0;
            m_a = '0; m_b = '0; m_c = '0;
            for (int i = 0; i < 16; i++) m_sel[i] = 0;
        end else begin
            for (int i = 0; i < 16; i++)
                src[i] = (m_sel[i] < 4) ? port_i[16*m_sel[i] + i] : 1'b0;
            src[19:16] = aux_i;
            setv = (m_b & ~m_c & m_rise) | (~m_b & m_c & m_fall);
            clrv = (wr_en && addr == 3'd3) ? wdata[19:0] : 20'd0;
            m_pend = (m_pend & ~clrv) | setv;
            if (wr_en) begin
                if (addr == 3'd0) m_mask = wdata[19:0];
                if (addr == 3'd1) m_rise = wdata[19:0];
                if (addr == 3'd2) m_fall = wdata[19:0];
                if (addr >= 3'd4)
                    for (int k = 0; k < 4; k++)
                        m_sel[(int'(addr) - 4)*4 + k] = int'(wdata[4*k +: 4]);
            end
            m_c = m_b; m_b = m_a; m_a = src;
        end
    end

    function automatic logic [6:0] model_irq();
        logic [6:0] v = '0;
        for (int i = 0; i < 16; i++) begin
            if (m_pend[i] && m_mask[i]) begin
                if (i < 5) v[i] = 1'b1;
                else if (i < 10) v[5] = 1'b1;
                else v[6] = 1'b1;
            end
        end
        return v;
    endfunction

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd0: v = {12'd0, m_mask};
            3'd1: v = {12'd0, m_rise};
            3'd2: v = {12'd0, m_fall};
            3'd3: v = {12'd0, m_pend};
            default:
                for (int k = 0; k < 4; k++)
                    v[4*k +: 4] = 4'(m_sel[(int'(a) - 4)*4 + k]);
        endcase
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (rdata !== model_rd(addr)) begin
                bad++;
                $display("FAIL R12 model compare: actual=%h expected=%h", rdata, model_rd(addr));
            end
            total++;
            if (irq_o !== model_irq()) begin
                bad++;
                $display("FAIL R9 model compare: actual=%h expected=%h", irq_o, model_irq());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(1);
        wr_en = 1'b0; addr = 3'd3; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        @(negedge clk);
        d = rdata;
        tick(1);
        addr = 3'd3;
    endtask

    task automatic get_irq(output logic [6:0] v);
        @(negedge clk);
        v = irq_o;
        tick(1);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  q;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d); chk("R1 reset register", d, 32'h0);
        end
        get_irq(q); chk("R1 reset irq", {25'd0, q}, 32'h0);

        // R12: register widths and layout
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R12 mask width", d, 32'h000F_FFFF);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h1234_5678); rd(3'd4, d); chk("R12 select word", d, 32'h0000_5678);

        // R10, R2: line0 from port 1 pin 0 on rising edge
        wr(3'd4, 32'h0000_0071);   // line0 code1, line1 code7
        wr(3'd1, 32'h1);
        port_i[0] = 1'b1; tick(4);
        rd(3'd3, d); chk("R10 unselected port ignored", d, 32'h0);
        port_i[16] = 1'b1; tick(3);
        rd(3'd3, d); chk("R2 rising edge pending", d, 32'h1);
        get_irq(q); chk("R8 masked line no irq", {25'd0, q}, 32'h0);
        wr(3'd0, 32'h1);
        get_irq(q); chk("R8 unmasked irq", {25'd0, q}, 32'h01);
        wr(3'd3, 32'h1);
        rd(3'd3, d); chk("R6 clear by one", d, 32'h0);

        // R10: reserved code gives a quiet source
        wr(3'd1, 32'h3); wr(3'd2, 32'h2);
        port_i[1] = 1'b1; port_i[17] = 1'b1; port_i[33] = 1'b1; port_i[49] = 1'b1; tick(4);
        port_i[1] = 1'b0; port_i[17] = 1'b0; port_i[33] = 1'b0; port_i[49] = 1'b0; tick(4);
        rd(3'd3, d); chk("R10 reserved code", d & 32'h2, 32'h0);

        // R3: line2 falling only
        wr(3'd1, 32'h0); wr(3'd2, 32'h4); wr(3'd3, 32'hFFFFF);
        port_i[2] = 1'b1; tick(4);
        rd(3'd3, d); chk("R3 rise ignored when fall only", d, 32'h0);
        port_i[2] = 1'b0; tick(3);
        rd(3'd3, d); chk("R3 falling edge pending", d, 32'h4);
        wr(3'd3, 32'h4);

        // R4, R9: line7 both edges from port 2 pin 7
        wr(3'd5, 32'h2000); wr(3'd1, 32'h80); wr(3'd2, 32'h80); wr(3'd0, 32'h80);
        port_i[39] = 1'b1; tick(3);
        rd(3'd3, d); chk("R4 rising with both", d, 32'h80);
        get_irq(q); chk("R9 line7 on group output 5", {25'd0, q}, 32'h20);
        wr(3'd3, 32'hFFFF_FF7F);
        rd(3'd3, d); chk("R6 zero bits keep value", d, 32'h80);
        wr(3'd3, 32'h80);
        port_i[39] = 1'b0; tick(3);
        rd(3'd3, d); chk("R4 falling with both", d, 32'h80);
        wr(3'd3, 32'h80);

        // R7: clear lands in the cycle the next edge sets the bit
        port_i[39] = 1'b1; tick(3);
        port_i[39] = 1'b0; tick(2);
        wr(3'd3, 32'h80);
        rd(3'd3, d); chk("R7 set wins over clear", d, 32'h80);
        wr(3'd3, 32'h80);
        rd(3'd3, d); chk("R7 later clear works", d, 32'h0);

        // R5: line3 with no trigger enables
        port_i[3] = 1'b1; tick(4); port_i[3] = 1'b0; tick(4);
        rd(3'd3, d); chk("R5 no trigger no pending", d, 32'h0);

        // R9: shared output for lines 10 and 11 held until both clear
        wr(3'd1, 32'hC00); wr(3'd0, 32'hC00);
        port_i[10] = 1'b1; port_i[11] = 1'b1; tick(3);
        get_irq(q); chk("R9 group output 6 set", {25'd0, q}, 32'h40);
        wr(3'd3, 32'h400);
        get_irq(q); chk("R9 group held by remaining line", {25'd0, q}, 32'h40);
        wr(3'd3, 32'h800);
        get_irq(q); chk("R9 group released", {25'd0, q}, 32'h0);

        // R9: direct output for line 4
        wr(3'd1, 32'h10); wr(3'd0, 32'h10);
        port_i[4] = 1'b1; tick(3);
        get_irq(q); chk("R9 line4 direct output", {25'd0, q}, 32'h10);
        wr(3'd3, 32'h10);

        // R11: auxiliary line
        wr(3'd1, 32'h1_0000); wr(3'd0, 32'hF_0000);
        aux_i[0] = 1'b1; tick(3);
        rd(3'd3, d); chk("R11 aux pending", d, 32'h1_0000);
        get_irq(q); chk("R11 aux never drives irq", {25'd0, q}, 32'h0);
        wr(3'd3, 32'h1_0000);
        tick(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule